// File: doc/BRIEF.md
# Duty-Cycle Temperature Demodulator

This block turns the square wave of a duty-cycle temperature sensor into a number. The sensor output is asynchronous. It is synchronised to the local sampling clock, and the length of each high and low interval is counted in sampling cycles. A measurement covers a fixed group of eight consecutive input periods, so that the sensor's internal chopping and matching sequence cancels out over the group. It returns the group's duty cycle as an unsigned Q0.16 word. Alongside it comes a signed temperature in sixteenths of a degree, taken from the straight-line fit T = (D − 0.30) / 0.0046.

A host pulses `start` to arm one measurement. The block ignores the partial period that is in progress when it is armed, and opens the group on the next rising edge. Two averaging modes are offered. The default averages the eight per-period ratios, which cancels the sensor's residuals best. The summed mode divides the total high time by the total period time. With `cont_en` held high, each group begins on the rising edge that closes the previous one, so no period is lost between results. A level that lasts too long stops the measurement and raises `err`.

The controller has four states. Its transitions are:
- IDLE goes to ARM on `start`.
- ARM goes to HIGH on a rising edge, and to IDLE on timeout.
- HIGH goes to LOW on a falling edge, and to IDLE on timeout.
- LOW goes to HIGH on a rising edge, unless it ends the last period of a group with `cont_en` low; that edge goes to IDLE instead.
- LOW goes to IDLE on timeout.
- Any state goes to ARM on `start`.

Top module: `duty_temp_demod`

## Requirements
- R1: The input passes through a two-flop synchroniser before any counting. After `start`, counting begins only at the first rising edge. A level held for N sampling cycles after the synchroniser counts as an interval of N.
- R2: A group is 8 periods, each running from one rising edge to the next. The result for a group follows the rising edge that ends its eighth period.
- R3: With `avg_mode`=0 the duty word is floor(Σ floor(tH·65536/(tH+tL)) / 8) over the group's periods.
- R4: With `avg_mode`=1 the duty word is floor(ΣtH·65536 / Σ(tH+tL)) over the group.
- R5: `temp_q` is a two's-complement value equal to floor((duty − 19661)·3478 / 65536), in units of 1/16 °C. It is updated together with `duty_q`.
- R6: `res_valid` is high for exactly one cycle per result. `duty_q` and `temp_q` hold their value until the next result.
- R7: With `cont_en`=1 at the end of a group, the closing rising edge also opens the next group. Back-to-back groups give one result each, in order.
- R8: With `cont_en`=0 at the end of a group, the block goes idle. Later input edges produce no result until the next `start`.
- R9: If no expected edge arrives before the interval counter reaches its all-ones value (2^CNT_W−1), the measurement is aborted, `err` goes to 1 and no result is produced. The next `start` clears `err`.
- R10: After reset, `res_valid`, `err`, `duty_q` and `temp_q` are all 0.
- R11: `avg_mode` is sampled at `start`. Changing it during a measurement does not affect that measurement's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_in | input | 1 | Asynchronous duty-cycle input from the sensor |
| start | input | 1 | Pulse to arm (or restart) a measurement |
| cont_en | input | 1 | 1: start the next group right after the current one |
| avg_mode | input | 1 | 0: mean of per-period ratios, 1: summed-time ratio |
| res_valid | output | 1 | One-cycle strobe for a new result |
| duty_q | output | 16 | Duty cycle, unsigned Q0.16 |
| temp_q | output | 16 | Temperature, signed, 1/16 °C per LSB |
| err | output | 1 | Timeout flag, sticky until the next start |

## Verification
- **Counting faults:** an off-by-one interval count or a counted partial period changes `duty_q` on the very next result, by a margin far above rounding. Varied per-period patterns therefore expose it at once.
- **Controller and averaging faults:** a wrong state transition or a wrong period index shows up as a missing, extra or late `res_valid` within one group of eight periods. A mix-up between the averaging paths shows as a differing duty word, because the patterns make the two modes disagree.
- **Timeout faults:** a stuck timeout shows as `err` failing to rise about 2^CNT_W cycles after the last edge.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_HI   = 2'd2,
        S_LO   = 2'd3
    } dtd_state_e;
endpackage

// File: rtl/dtd_edge_sync.sv
module dtd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/dtd_restore_div.sv
module dtd_restore_div #(
    parameter int W = 22,
    parameter int F = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [F-1:0] q,
    output logic         done,
    output logic         busy
);
    localparam int SW = $clog2(F + 1);
    localparam int PW = W + F + 1;

    logic [W-1:0]  rem, dreg, nreg;
    logic [SW-1:0] step;
    logic [W:0]    trial;

    assign trial = {rem, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0; dreg <= '0; nreg <= '0; q <= '0;
            step <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                rem  <= num;
                dreg <= den;
                nreg <= num;
                q    <= '0;
                step <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, dreg}) begin
                    rem <= W'(trial - {1'b0, dreg});
                    q   <= {q[F-2:0], 1'b1};
                end else begin
                    rem <= W'(trial);
                    q   <= {q[F-2:0], 1'b0};
                end
                step <= step + 1'b1;
                if (step == SW'(F - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R3: quotient is the floor of num*2^F/den
    p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((PW'(q) * PW'(dreg) <= (PW'(nreg) << F)) &&
                  ((PW'(q) + 1'b1) * PW'(dreg) > (PW'(nreg) << F))));
endmodule

// File: rtl/duty_temp_demod.sv
module duty_temp_demod #(
    parameter int CNT_W  = 18,
    parameter int NPER   = 8,
    parameter int FRAC_W = 16,
    parameter int B_Q    = 19661,
    parameter int RECIP  = 3478,
    parameter int RSHIFT = 16,
    parameter int TEMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sense_in,
    input  logic                     start,
    input  logic                     cont_en,
    input  logic                     avg_mode,
    output logic                     res_valid,
    output logic [FRAC_W-1:0]        duty_q,
    output logic signed [TEMP_W-1:0] temp_q,
    output logic                     err
);
    import dtd_pkg::*;

    localparam int IDX_W  = $clog2(NPER);
    localparam int SUM_W  = CNT_W + 1 + IDX_W;
    localparam int ACC_W  = FRAC_W + IDX_W;
    localparam int PROD_W = FRAC_W + 2 + 18;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic signed [FRAC_W+1:0] B_S     = (FRAC_W+2)'(B_Q);
    localparam logic signed [PROD_W-1:0] RECIP_S = PROD_W'(RECIP);

    dtd_state_e state, state_nxt;

    logic             rise, fall, tmo, last, period_end;
    logic [CNT_W-1:0] cnt, th_r;
    logic [IDX_W-1:0] pidx;
    logic [SUM_W-1:0] sum_h, sum_t, div_num, div_den;
    logic [ACC_W-1:0] acc, acc_sum;
    logic             fin_pend, mode_r;
    logic             div_start, div_done, div_busy, div_abort;
    logic [FRAC_W-1:0] div_q, duty_nxt;
    logic signed [FRAC_W+1:0] dm;
    logic signed [PROD_W-1:0] prod;

    dtd_edge_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(sense_in), .rise(rise), .fall(fall)
    );

    dtd_restore_div #(.W(SUM_W), .F(FRAC_W)) div_i (
        .clk(clk), .rst_n(rst_n), .abort(div_abort), .start(div_start),
        .num(div_num), .den(div_den), .q(div_q), .done(div_done), .busy(div_busy)
    );

    assign last       = (pidx == IDX_W'(NPER - 1));
    assign period_end = (state == S_LO) && rise && !start;
    assign div_start  = period_end && (!mode_r || last);
    assign div_abort  = start || tmo;
    assign div_num    = mode_r ? sum_h + SUM_W'(th_r) : SUM_W'(th_r);
    assign div_den    = mode_r ? sum_t + SUM_W'(th_r) + SUM_W'(cnt)
                               : SUM_W'(th_r) + SUM_W'(cnt);

    // timeout: counter at its ceiling with no awaited edge this cycle
    always_comb begin
        tmo = 1'b0;
        if (!start && cnt == CNT_MAX) begin
            unique case (state)
                S_ARM:   tmo = !(rise || fall);
                S_HI:    tmo = !fall;
                S_LO:    tmo = !rise;
                default: tmo = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (start) state_nxt = S_ARM;
            S_ARM: begin
                if (start)     state_nxt = S_ARM;
                else if (rise) state_nxt = S_HI;
                else if (tmo)  state_nxt = S_IDLE;
            end
            S_HI: begin
                if (start)     state_nxt = S_ARM;
                else if (fall) state_nxt = S_LO;
                else if (tmo)  state_nxt = S_IDLE;
            end
            S_LO: begin
                if (start)     state_nxt = S_ARM;
                else if (rise) state_nxt = (last && !cont_en) ? S_IDLE : S_HI;
                else if (tmo)  state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // result arithmetic
    assign acc_sum  = acc + ACC_W'(div_q);
    assign duty_nxt = mode_r ? div_q : FRAC_W'(acc_sum >> IDX_W);
    assign dm       = $signed({2'b00, duty_nxt}) - B_S;
    assign prod     = PROD_W'(dm) * RECIP_S;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0; duty_q <= '0; temp_q <= '0; err <= 1'b0;
            cnt <= '0; th_r <= '0; pidx <= '0; sum_h <= '0; sum_t <= '0;
            acc <= '0; fin_pend <= 1'b0; mode_r <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (start) begin
                err <= 1'b0; mode_r <= avg_mode; cnt <= '0; pidx <= '0;
                sum_h <= '0; sum_t <= '0; acc <= '0; fin_pend <= 1'b0;
            end else if (tmo) begin
                err <= 1'b1; pidx <= '0;
                sum_h <= '0; sum_t <= '0; acc <= '0; fin_pend <= 1'b0;
            end else begin
                unique case (state)
                    S_ARM: cnt <= (rise || fall) ? CNT_W'(1) : cnt + 1'b1;
                    S_HI: begin
                        if (fall) begin
                            th_r <= cnt;
                            cnt  <= CNT_W'(1);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_LO: begin
                        if (rise) begin
                            cnt <= CNT_W'(1);
                            if (last) begin
                                pidx     <= '0;
                                fin_pend <= 1'b1;
                                sum_h    <= '0;
                                sum_t    <= '0;
                            end else begin
                                pidx  <= pidx + 1'b1;
                                sum_h <= sum_h + SUM_W'(th_r);
                                sum_t <= sum_t + SUM_W'(th_r) + SUM_W'(cnt);
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
                if (div_done) begin
                    if (fin_pend) begin
                        res_valid <= 1'b1;
                        duty_q    <= duty_nxt;
                        temp_q    <= TEMP_W'(prod >>> RSHIFT);
                        acc       <= '0;
                        fin_pend  <= 1'b0;
                    end else begin
                        acc <= acc_sum;
                    end
                end
            end
        end
    end

    // R6: result strobe lasts one cycle
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9: an aborted measurement yields no result while flagged
    p_err_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !res_valid);
    // R2: a period division is only launched on an idle divider
    p_div_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> !div_busy);
    // R1: counting opens on the first rising edge after arming
    p_arm_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM && rise && !start) |=> (state == S_HI));
    // R8: closing edge of a single group returns the controller to idle
    p_single_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && last && !cont_en) |=> (state == S_IDLE));
endmodule

// File: tb/duty_temp_demod_tb_top.sv
module duty_temp_demod_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_in = 1'b0, start = 1'b0, cont_en = 1'b0, avg_mode = 1'b0;
    logic res_valid, err;
    logic [15:0] duty_q;
    logic signed [15:0] temp_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    duty_temp_demod #(.CNT_W(TB_CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sense_in(sense_in), .start(start),
        .cont_en(cont_en), .avg_mode(avg_mode), .res_valid(res_valid),
        .duty_q(duty_q), .temp_q(temp_q), .err(err)
    );

    int total = 0, bad = 0;
    int ph[0:15], pl[0:15];
    int nres = 0, dbl = 0;
    logic pv = 1'b0;
    logic [15:0] rd[0:7];
    logic signed [15:0] rt[0:7];

    always @(negedge clk) begin
        if (res_valid) begin
            rd[nres % 8] = duty_q;
            rt[nres % 8] = temp_q;
            nres++;
        end
        if (pv && res_valid) dbl++;
        pv = res_valid;
    end

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_per(int base);
        longint s = 0;
        for (int i = base; i < base + 8; i++)
            s += (longint'(ph[i]) * 65536) / (ph[i] + pl[i]);
        return s / 8;
    endfunction

    function automatic longint exp_sum(int base);
        longint sh = 0, st = 0;
        for (int i = base; i < base + 8; i++) begin
            sh += ph[i];
            st += ph[i] + pl[i];
        end
        return (sh * 65536) / st;
    endfunction

    function automatic longint exp_temp(longint d);
        longint n = (d - 19661) * 3478;
        longint q = n / 65536;
        if (n < 0 && q * 65536 != n) q--;
        return q;
    endfunction

    task automatic hold(logic v, int n);
        sense_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic fill(int h0, int l0, int hs, int ls);
        for (int i = 0; i < 16; i++) begin
            ph[i] = h0 + ((i * 37) % hs);
            pl[i] = l0 + ((i * 53) % ls);
        end
    endtask

    // arm with a partial period in progress, then drive ngroups*8 periods
    task automatic drive_groups(logic mode, logic cont, int ngroups, logic flip);
        avg_mode = mode;
        cont_en  = cont;
        hold(1'b1, 20);
        pulse_start();
        hold(1'b1, 9);
        hold(1'b0, 15);
        for (int i = 0; i < 8 * ngroups; i++) begin
            if (i == 8 * ngroups - 1) cont_en = 1'b0;
            if (flip && i == 3) avg_mode = ~mode;
            hold(1'b1, ph[i]);
            hold(1'b0, pl[i]);
        end
        hold(1'b1, 30);
        hold(1'b0, 40);
    endtask

    task automatic t_reset();
        chk("R10", "res_valid", res_valid, 0);
        chk("R10", "err", err, 0);
        chk("R10", "duty_q", duty_q, 0);
        chk("R10", "temp_q", temp_q, 0);
    endtask

    task automatic t_group(logic mode, string req, int h0, int l0);
        int n0;
        longint ed;
        fill(h0, l0, 23, 29);
        n0 = nres;
        drive_groups(mode, 1'b0, 1, 1'b0);
        ed = mode ? exp_sum(0) : exp_per(0);
        chk("R2", "result count", nres - n0, 1);
        chk(req, "duty (R1 partial period discarded)", rd[n0 % 8], ed);
        chk("R5", "temp", rt[n0 % 8], exp_temp(ed));
    endtask

    task automatic t_idle_after();
        int n0;
        logic [15:0] d0;
        n0 = nres;
        d0 = duty_q;
        for (int i = 0; i < 10; i++) begin
            hold(1'b1, 50);
            hold(1'b0, 60);
        end
        hold(1'b1, 40);
        chk("R8", "no result while idle", nres - n0, 0);
        chk("R6", "duty held", duty_q, d0);
    endtask

    task automatic t_continuous(logic mode);
        int n0;
        fill(60, 90, 31, 41);
        for (int i = 8; i < 16; i++) ph[i] = ph[i] + 150;
        n0 = nres;
        drive_groups(mode, 1'b1, 2, 1'b0);
        chk("R7", "two results", nres - n0, 2);
        chk("R7", "group 1 duty", rd[n0 % 8], mode ? exp_sum(0) : exp_per(0));
        chk("R7", "group 2 duty", rd[(n0 + 1) % 8], mode ? exp_sum(8) : exp_per(8));
    endtask

    task automatic t_mode_latch();
        int n0;
        fill(30, 200, 17, 90);
        n0 = nres;
        drive_groups(1'b0, 1'b0, 1, 1'b1);
        chk("R11", "mode latched at start", rd[n0 % 8], exp_per(0));
        chk("R11", "modes disagree on pattern", (exp_per(0) != exp_sum(0)) ? 1 : 0, 1);
    endtask

    task automatic t_timeout();
        int n0;
        n0 = nres;
        hold(1'b0, 20);
        pulse_start();
        hold(1'b0, 10);
        hold(1'b1, 5000);
        chk("R9", "err after stuck high", err, 1);
        chk("R9", "no result", nres - n0, 0);
        hold(1'b0, 10);
        pulse_start();
        @(negedge clk);
        chk("R9", "err cleared by start", err, 0);
        hold(1'b0, 4500);
        chk("R9", "err after no edge in arm", err, 1);
        chk("R9", "no result", nres - n0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_group(1'b0, "R3", 200, 150);
        t_group(1'b1, "R4", 200, 150);
        t_idle_after();
        t_group(1'b0, "R3", 20, 180);
        t_group(1'b1, "R4", 300, 35);
        t_continuous(1'b0);
        t_continuous(1'b1);
        t_mode_latch();
        t_timeout();
        t_group(1'b0, "R3", 120, 80);
        chk("R6", "double-cycle strobes", dbl, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule